// File: doc/BRIEF.md
# Page-Frame Eviction Selector with Clock and Usage-Class Policies

When a page fault needs a free slot in physical memory, this block chooses which frame to give up. It keeps a referenced bit and a modified bit for each frame, plus a circular hand. It can run one of two policies. In the second-chance clock policy, the hand moves around the circle one frame per cycle. Each referenced frame it passes loses its referenced bit, and the first frame it finds unreferenced is the victim. In the usage-class policy, every frame is ranked by a two-bit class. The victim is taken in a single cycle from the lowest class that has any member.

Other logic reports frame accesses (reads, or writes that also dirty the frame). It also reports page installs into a frame and an aging tick that clears every referenced bit. To get a victim, it raises a request. The block returns the victim index together with a dirty flag, which says the frame must be written back before it is reused. The frame count must be a power of two.

Top module: `nru_victim_select`

## Requirements
- R1: After a synchronous reset, every referenced and modified bit is 0, the hand is 0, and `busy_o` and `done_o` are 0. The first clock-policy request therefore returns frame 0, clean, two cycles after the request is sampled.
- R2: An access marks its frame referenced. An access with `acc_wr_i`=1 also marks it modified. `age_tick_i` clears all referenced bits and leaves the modified bits alone.
- R3: With `policy_i`=0 (clock), the frame under the hand is examined once per cycle. A referenced frame has its bit cleared and the hand steps on. The first unreferenced frame becomes the victim. With k referenced frames passed, `done_o` rises k+2 clock edges after the request edge.
- R4: In clock policy, if every frame is referenced, one full loop clears all bits and the victim is the frame where the sweep started. The scan never lasts more than 2×N_FRAMES cycles.
- R5: With `policy_i`=1 (class), a frame's class is 2×referenced + modified. The victim has the lowest class present, and `done_o` rises two edges after the request edge.
- R6: In class policy, ties within the lowest class go to the first frame at or after the hand, counting upward with wrap-around.
- R7: When a victim is reported, the hand equals victim+1 modulo N_FRAMES. The hand does not move while the block is idle.
- R8: `dirty_o` equals the victim's modified bit at the moment it is chosen.
- R9: Installing a page into a frame clears its modified bit and sets its referenced bit.
- R10: `busy_o` is high from the edge after the request until the victim edge. Requests made while busy are ignored. `done_o` is a single-cycle pulse, and `busy_o` falls exactly when it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_i | input | 1 | 0 = clock sweep, 1 = class priority; latched with the request |
| acc_en_i | input | 1 | Frame access strobe |
| acc_idx_i | input | IDX_W | Accessed frame |
| acc_wr_i | input | 1 | Access is a write (marks modified) |
| inst_en_i | input | 1 | Page install strobe |
| inst_idx_i | input | IDX_W | Frame receiving a fresh page |
| age_tick_i | input | 1 | Periodic clear of all referenced bits |
| req_i | input | 1 | Request a victim |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse: victim valid |
| victim_o | output | IDX_W | Chosen frame |
| dirty_o | output | 1 | Victim needs write-back |
| hand_o | output | IDX_W | Current hand position |

## Verification
The bench walks all 256 referenced-bit patterns under each policy. Each pattern is paired with a modified pattern derived arithmetically from it. Because the hand carries over from one search to the next, the same pattern is met at many hand positions. In clock policy, the measured latency separates an immediate pick, a partial sweep and the full-loop fallback. In class policy, mixing modified and referenced bits separates the class order and the tie-break from a plain first-free scan. Dedicated cases cover the state right after reset, an install overriding a dirty referenced frame, and a repeated request during a long sweep.

// File: rtl/nru_sel_pkg.sv
package nru_sel_pkg;

    typedef enum logic {
        POL_CLOCK = 1'b0,
        POL_CLASS = 1'b1
    } policy_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

    typedef logic [1:0] usage_class_t;

    // Rank of a frame: referenced dominates modified.
    function automatic usage_class_t class_of(input logic refd, input logic dirty);
        return {refd, dirty};
    endfunction

endpackage

// File: rtl/nru_frame_bits.sv
module nru_frame_bits #(
    parameter int N_FRAMES = 8,
    parameter int IDX_W    = $clog2(N_FRAMES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic                acc_en_i,
    input  logic [IDX_W-1:0]    acc_idx_i,
    input  logic                acc_wr_i,
    input  logic                inst_en_i,
    input  logic [IDX_W-1:0]    inst_idx_i,
    input  logic                clr_en_i,
    input  logic [IDX_W-1:0]    clr_idx_i,
    output logic [N_FRAMES-1:0] ref_o,
    output logic [N_FRAMES-1:0] mod_o
);

    for (genvar g = 0; g < N_FRAMES; g++) begin : g_frame
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);

        logic r_q;
        logic m_q;
        logic acc_hit;
        logic inst_hit;
        logic clr_hit;

        assign acc_hit  = acc_en_i  && (acc_idx_i  == MY_IDX);
        assign inst_hit = inst_en_i && (inst_idx_i == MY_IDX);
        assign clr_hit  = clr_en_i  && (clr_idx_i  == MY_IDX);

        // Later assignments win: set beats clear, install beats write.
        always_ff @(posedge clk) begin
            if (rst) begin
                r_q <= 1'b0;
                m_q <= 1'b0;
            end else begin
                if (tick_i || clr_hit) r_q <= 1'b0;
                if (acc_hit || inst_hit) r_q <= 1'b1;
                if (acc_hit && acc_wr_i) m_q <= 1'b1;
                if (inst_hit) m_q <= 1'b0;
            end
        end

        assign ref_o[g] = r_q;
        assign mod_o[g] = m_q;
    end

endmodule

// File: rtl/nru_class_pick.sv
module nru_class_pick
    import nru_sel_pkg::*;
#(
    parameter int N_FRAMES = 8,
    parameter int IDX_W    = $clog2(N_FRAMES)
) (
    input  logic [N_FRAMES-1:0] ref_i,
    input  logic [N_FRAMES-1:0] mod_i,
    input  logic [IDX_W-1:0]    start_i,
    output logic [IDX_W-1:0]    pick_o,
    output usage_class_t        class_o
);

    usage_class_t best;
    logic         found;
    logic [IDX_W-1:0] idx;

    always_comb begin
        best = 2'b11;
        for (int i = 0; i < N_FRAMES; i++) begin
            if (class_of(ref_i[i], mod_i[i]) < best)
                best = class_of(ref_i[i], mod_i[i]);
        end

        found  = 1'b0;
        pick_o = start_i;
        idx    = start_i;
        for (int k = 0; k < N_FRAMES; k++) begin
            idx = start_i + IDX_W'(k);
            if (!found && (class_of(ref_i[idx], mod_i[idx]) == best)) begin
                pick_o = idx;
                found  = 1'b1;
            end
        end
        class_o = best;
    end

endmodule

// File: rtl/nru_victim_select.sv
module nru_victim_select
    import nru_sel_pkg::*;
#(
    parameter int N_FRAMES = 8,
    localparam int IDX_W   = $clog2(N_FRAMES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             policy_i,
    input  logic             acc_en_i,
    input  logic [IDX_W-1:0] acc_idx_i,
    input  logic             acc_wr_i,
    input  logic             inst_en_i,
    input  logic [IDX_W-1:0] inst_idx_i,
    input  logic             age_tick_i,
    input  logic             req_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [IDX_W-1:0] victim_o,
    output logic             dirty_o,
    output logic [IDX_W-1:0] hand_o
);

    scan_state_e      state_q;
    policy_e          pol_q;
    logic [IDX_W-1:0] hand_q;
    logic             done_q;
    logic [IDX_W-1:0] victim_q;
    logic             dirty_q;

    logic [N_FRAMES-1:0] ref_bits;
    logic [N_FRAMES-1:0] mod_bits;
    logic [IDX_W-1:0]    pick_idx;
    usage_class_t        pick_class;

    logic             sweep_clr;
    logic             finish;
    logic [IDX_W-1:0] finish_idx;

    nru_frame_bits #(.N_FRAMES(N_FRAMES), .IDX_W(IDX_W)) u_bits (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (age_tick_i),
        .acc_en_i   (acc_en_i),
        .acc_idx_i  (acc_idx_i),
        .acc_wr_i   (acc_wr_i),
        .inst_en_i  (inst_en_i),
        .inst_idx_i (inst_idx_i),
        .clr_en_i   (sweep_clr),
        .clr_idx_i  (hand_q),
        .ref_o      (ref_bits),
        .mod_o      (mod_bits)
    );

    nru_class_pick #(.N_FRAMES(N_FRAMES), .IDX_W(IDX_W)) u_pick (
        .ref_i   (ref_bits),
        .mod_i   (mod_bits),
        .start_i (hand_q),
        .pick_o  (pick_idx),
        .class_o (pick_class)
    );

    // Decide this cycle whether the search ends and on which frame.
    always_comb begin
        sweep_clr  = 1'b0;
        finish     = 1'b0;
        finish_idx = hand_q;
        if (state_q == ST_SCAN) begin
            if (pol_q == POL_CLASS) begin
                finish     = 1'b1;
                finish_idx = pick_idx;
            end else if (ref_bits[hand_q]) begin
                sweep_clr = 1'b1;
            end else begin
                finish = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            pol_q    <= POL_CLOCK;
            hand_q   <= '0;
            done_q   <= 1'b0;
            victim_q <= '0;
            dirty_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_i) begin
                        state_q <= ST_SCAN;
                        pol_q   <= policy_e'(policy_i);
                    end
                end
                ST_SCAN: begin
                    if (finish) begin
                        state_q  <= ST_IDLE;
                        done_q   <= 1'b1;
                        victim_q <= finish_idx;
                        dirty_q  <= mod_bits[finish_idx];
                        hand_q   <= finish_idx + 1'b1;
                    end else begin
                        hand_q <= hand_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o   = (state_q == ST_SCAN);
    assign done_o   = done_q;
    assign victim_o = victim_q;
    assign dirty_o  = dirty_q;
    assign hand_o   = hand_q;

endmodule

// File: rtl/nru_victim_select_chk.sv
module nru_victim_select_chk
    import nru_sel_pkg::*;
#(
    parameter int N_FRAMES = 8,
    parameter int IDX_W    = $clog2(N_FRAMES)
) (
    input logic             clk,
    input logic             rst,
    input logic             busy_o,
    input logic             done_o,
    input logic [IDX_W-1:0] victim_o,
    input logic [IDX_W-1:0] hand_o,
    input policy_e          pol_q
);

    localparam int CW = $clog2(2 * N_FRAMES + 2) + 1;

    logic [CW-1:0] scan_cnt;

    always_ff @(posedge clk) begin
        if (rst)         scan_cnt <= '0;
        else if (busy_o) scan_cnt <= scan_cnt + 1'b1;
        else             scan_cnt <= '0;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);                                            // R10
    AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);                                      // R10
    AST_HAND_PAST_VICTIM: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (hand_o == IDX_W'(victim_o + 1'b1)));                // R7
    AST_HAND_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy_o |=> $stable(hand_o));                                   // R7
    AST_CLASS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (busy_o && pol_q == POL_CLASS) |=> !busy_o);                    // R5
    AST_SCAN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        scan_cnt <= CW'(2 * N_FRAMES));                                 // R4

endmodule

bind nru_victim_select nru_victim_select_chk #(.N_FRAMES(N_FRAMES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .victim_o (victim_o),
    .hand_o   (hand_o),
    .pol_q    (pol_q)
);

// File: tb/nru_victim_select_test.sv
module nru_victim_select_test;

    localparam int NF = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          policy_i = 1'b0;
    logic          acc_en_i = 1'b0;
    logic [IW-1:0] acc_idx_i = '0;
    logic          acc_wr_i = 1'b0;
    logic          inst_en_i = 1'b0;
    logic [IW-1:0] inst_idx_i = '0;
    logic          age_tick_i = 1'b0;
    logic          req_i = 1'b0;
    logic          busy_o;
    logic          done_o;
    logic [IW-1:0] victim_o;
    logic          dirty_o;
    logic [IW-1:0] hand_o;

    int checks = 0;
    int fails  = 0;
    int mref[NF];
    int mmod[NF];
    int mhand = 0;

    always #10 clk = ~clk;

    nru_victim_select #(.N_FRAMES(NF)) uut (
        .clk(clk), .rst(rst), .policy_i(policy_i),
        .acc_en_i(acc_en_i), .acc_idx_i(acc_idx_i), .acc_wr_i(acc_wr_i),
        .inst_en_i(inst_en_i), .inst_idx_i(inst_idx_i),
        .age_tick_i(age_tick_i), .req_i(req_i),
        .busy_o(busy_o), .done_o(done_o), .victim_o(victim_o),
        .dirty_o(dirty_o), .hand_o(hand_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic quiet();
        acc_en_i = 0; acc_wr_i = 0; inst_en_i = 0; age_tick_i = 0; req_i = 0;
    endtask

    task automatic op_install(input int f);
        @(negedge clk); quiet(); inst_en_i = 1; inst_idx_i = IW'(f);
        mref[f] = 1; mmod[f] = 0;
    endtask

    task automatic op_access(input int f, input bit wr);
        @(negedge clk); quiet(); acc_en_i = 1; acc_idx_i = IW'(f); acc_wr_i = wr;
        mref[f] = 1; if (wr) mmod[f] = 1;
    endtask

    task automatic op_tick();
        @(negedge clk); quiet(); age_tick_i = 1;
        for (int i = 0; i < NF; i++) mref[i] = 0;
    endtask

    // Reach referenced pattern rp and modified pattern mp from any state.
    task automatic load(input int rp, input int mp);
        for (int i = 0; i < NF; i++) op_install(i);
        for (int i = 0; i < NF; i++) if (mp[i]) op_access(i, 1'b1);
        op_tick();
        for (int i = 0; i < NF; i++) if (rp[i]) op_access(i, 1'b0);
        @(negedge clk); quiet();
    endtask

    task automatic request(input int pol, input int inst_f, input bit extra);
        int lat, exp_v, exp_lat, k, idx, best, exp_d;
        bit busy_ok;
        if (inst_f >= 0) begin
            op_install(inst_f);
            @(negedge clk); quiet();
        end
        if (pol == 0) begin
            k = 0; idx = mhand;
            while (k < NF && mref[idx] == 1) begin
                mref[idx] = 0; idx = (idx + 1) % NF; k++;
            end
            exp_v = idx; exp_lat = 2 + k;
        end else begin
            k = 0; best = 3;
            for (int i = 0; i < NF; i++)
                if (2 * mref[i] + mmod[i] < best) best = 2 * mref[i] + mmod[i];
            exp_v = -1;
            for (int j = 0; j < NF; j++) begin
                idx = (mhand + j) % NF;
                if (exp_v < 0 && 2 * mref[idx] + mmod[idx] == best) exp_v = idx;
            end
            exp_lat = 2;
        end
        exp_d = mmod[exp_v];

        @(negedge clk); quiet(); policy_i = pol[0]; req_i = 1;
        @(negedge clk); req_i = 0; lat = 1; busy_ok = 1;
        while (!done_o && lat < 40) begin
            if (!busy_o) busy_ok = 0;
            req_i = (extra && lat == 3);
            @(negedge clk); lat++;
        end
        req_i = 0;

        if (inst_f >= 0)
            chk(victim_o == IW'(exp_v), "R9 installed frame victim", victim_o, exp_v);
        else if (pol == 0)
            chk(victim_o == IW'(exp_v), (k == NF) ? "R4 full-loop victim" : "R3 clock victim",
                victim_o, exp_v);
        else
            chk(victim_o == IW'(exp_v), "R2/R5/R6 class victim", victim_o, exp_v);
        chk(lat == exp_lat, (pol == 0) ? "R3 clock latency" : "R5 class latency", lat, exp_lat);
        chk(dirty_o == exp_d[0], (inst_f >= 0) ? "R9 install clears dirty" : "R8 dirty flag",
            dirty_o, exp_d);
        chk(hand_o == IW'((exp_v + 1) % NF), "R7 hand after victim", hand_o, (exp_v + 1) % NF);
        chk(busy_ok, "R10 busy during search", busy_ok, 1);
        mhand = (exp_v + 1) % NF;

        @(negedge clk);
        chk(!done_o && !busy_o, "R10 single done pulse, back to idle",
            {done_o, busy_o}, 0);
    endtask

    initial begin
        for (int i = 0; i < NF; i++) begin mref[i] = 0; mmod[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        chk(busy_o == 0, "R1 busy after reset", busy_o, 0);
        chk(done_o == 0, "R1 done after reset", done_o, 0);
        chk(hand_o == 0, "R1 hand after reset", hand_o, 0);
        // R1: cleared bits make frame 0 an immediate clean clock victim.
        request(0, -1, 1'b0);

        // R9: all frames dirty+referenced, then one fresh install wins class 2.
        load(8'hFF, 8'hFF);
        request(1, 3, 1'b0);

        // R4 + R10: full loop with a repeated request mid-sweep.
        load(8'hFF, 8'h5A);
        request(0, -1, 1'b1);

        // R2: write marks dirty; tick keeps dirty but drops referenced.
        load(8'h00, 8'h00);
        op_access(5, 1'b1);
        op_tick();
        @(negedge clk); quiet();
        request(1, -1, 1'b0);

        for (int pol = 0; pol < 2; pol++) begin
            for (int p = 0; p < 256; p++) begin
                load(p, ((p * 37 + 11) ^ (p >> 3)) & 8'hFF);
                request(pol, -1, 1'b0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule